// File: doc/BRIEF.md
# Alternating-Strobe Two-Wire Serial Receiver

This block listens to a two-wire serial bus on which neither wire is a fixed clock. For every bit, one wire acts as the strobe and the other carries the data. The roles swap after each bit. Both wires enter through a reset-to-high synchronizer. The receiver stays idle until it sees a framing pattern on wire A: high, then low, then high again. From that point, it captures one data bit on each falling edge of the current strobe wire.

Bits are packed most significant first. Each finished byte is presented for exactly one cycle with a valid pulse. No terminator pattern is decoded. The frame ends when an inactivity timer expires. That timer is restarted once per byte, when the bit at a fixed position is captured. On expiry, the block emits a one-cycle done pulse that carries the number of complete bytes received, drops any partly assembled byte, and starts waiting for the framing pattern again.

Top module: `altrx_rx`

## Requirements
- R1: After reset, and after every frame end, no bit is captured until wire A has been seen high, then low, then high again. Activity on wire B during that wait has no effect.
- R2: The first bit of every byte (bit 7) is the value on wire B at a falling edge of wire A.
- R3: Strobe and data roles alternate on every bit. Odd bit positions (7, 5, 3, 1) are strobed by wire A and read from wire B. Even positions (6, 4, 2, 0) are strobed by wire B and read from wire A.
- R4: The captured data value is the synchronized data wire in the same cycle the strobe fall is detected, not a later one.
- R5: Bits fill positions 7 down to 0. After bit 0, `byte_data` holds the byte and `byte_valid` is high for exactly one cycle, SYNC_STAGES+1 clock edges after the strobe fall reaches the input pin.
- R6: Capturing bit position CLEAR_BIT (default 4) restarts the inactivity timer. `frame_done` rises exactly TIMEOUT_CYCLES clock edges after the edge that captured that bit, unless another restart occurs first.
- R7: The timer starts counting at the edge where arming completes, so a frame with no bytes still ends. `frame_done` is a one-cycle pulse, and `frame_count` equals the number of complete bytes in the frame (modulo 2^COUNT_W).
- R8: A partial byte in progress at expiry is discarded. It is not counted, and the next frame starts again at bit 7.
- R9: If a byte completes in the same cycle the timer expires, the byte is still delivered and is included in `frame_count`.
- R10: If the timer restart at bit CLEAR_BIT falls in the same cycle as expiry, the restart wins and the frame continues.
- R11: Strobe edges that arrive after expiry are ignored until the block is armed again.
- R12: Reset clears `byte_valid`, `frame_done`, `byte_data` and `frame_count` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_a | input | 1 | Bus wire A, asynchronous; strobe for odd bit positions |
| line_b | input | 1 | Bus wire B, asynchronous; strobe for even bit positions |
| byte_data | output | DATA_W | Last completed byte |
| byte_valid | output | 1 | One-cycle pulse when `byte_data` is updated |
| frame_done | output | 1 | One-cycle pulse at frame end (timer expiry) |
| frame_count | output | COUNT_W | Complete bytes in the frame just ended, valid with `frame_done` |

## Verification
Two functions can fall in the same cycle here: completing a byte and expiring the timer. A related pair is the once-per-byte timer restart landing in the expiry cycle. The bench places the final strobe fall of a byte at the exact drive cycle whose capture edge is the expiry edge, then one cycle later. The first case expects both pulses together with the byte counted. The second expects the byte to be dropped and the count one lower. The restart collision is provoked the same way with the bit-4 strobe, and it is judged by the absence of a done pulse at the old deadline and the arrival of one at the new deadline.

// File: rtl/altrx_pkg.sv
package altrx_pkg;

   // Receive sequencer: three arming steps, then bit capture.
   typedef enum logic [1:0] {
      RX_IDLE_HI = 2'd0,   // waiting for wire A high
      RX_WAIT_LO = 2'd1,   // waiting for wire A low
      RX_WAIT_HI = 2'd2,   // waiting for wire A high again
      RX_RECV    = 2'd3    // capturing bits, timer running
   } rx_state_e;

   // Index of each wire in the two-bit line vector.
   localparam int WIRE_A = 0;
   localparam int WIRE_B = 1;

endpackage

// File: rtl/altrx_sync.sv
// Multi-stage synchronizer with falling-edge detection for a vector of lines.
module altrx_sync #(
   parameter int          STAGES    = 2,
   parameter int          WIDTH     = 2,
   parameter logic [31:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall
);

   localparam logic [WIDTH-1:0] RST_LVL = RESET_VAL[WIDTH-1:0];

   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("altrx_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign level = raw;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_LVL;
            end else begin
               pipe_q[0] <= raw;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign level = pipe_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= RST_LVL;
      else        prev_q <= level;
   end

   assign fall = prev_q & ~level;

endmodule

// File: rtl/altrx_timer.sv
// Inactivity timer: counts while running, restarts on clear, flags expiry.
module altrx_timer #(
   parameter int LIMIT = 262144,
   parameter int CNT_W = $clog2(LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic expire
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("altrx_timer: LIMIT must be at least 2");
      end
   endgenerate

   assign at_last = (cnt_q == LAST);
   // A restart in the final cycle keeps the frame alive.
   assign expire  = run && !clear && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run || clear || expire) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/altrx_assemble.sv
// MSB-first byte assembly. Also tells which wire strobes the next bit.
module altrx_assemble #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              take,
   input  logic              bit_val,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              strobe_a,
   output logic              word_done,
   output logic [DATA_W-1:0] word_value
);

   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shreg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= TOP_IDX;
         shreg_q <= '0;
      end else if (restart) begin
         idx_q   <= TOP_IDX;
      end else if (take) begin
         shreg_q[idx_q] <= bit_val;
         idx_q          <= (idx_q == '0) ? TOP_IDX : idx_q - 1'b1;
      end
   end

   assign bit_idx    = idx_q;
   // DATA_W is even, so the top bit position is odd and is strobed by wire A.
   assign strobe_a   = idx_q[0];
   assign word_done  = take && !restart && (idx_q == '0);
   assign word_value = {shreg_q[DATA_W-1:1], bit_val};

endmodule

// File: rtl/altrx_rx.sv
// Alternating-strobe two-wire receiver with inactivity frame end.
module altrx_rx
   import altrx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int TIMEOUT_CYCLES = 262144,
   parameter int CLEAR_BIT      = 4,
   parameter int COUNT_W        = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_a,
   input  logic               line_b,
   output logic [DATA_W-1:0]  byte_data,
   output logic               byte_valid,
   output logic               frame_done,
   output logic [COUNT_W-1:0] frame_count
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] CLR_IDX = IDX_W'(CLEAR_BIT);

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("altrx_rx: DATA_W must be even and at least 2");
      end
      if (CLEAR_BIT < 0 || CLEAR_BIT >= DATA_W) begin : g_bad_clear
         $error("altrx_rx: CLEAR_BIT must index a bit of the word");
      end
      if (COUNT_W < 1) begin : g_bad_count
         $error("altrx_rx: COUNT_W must be positive");
      end
   endgenerate

   // ---------------- synchronizer and edge detect
   logic [1:0] raw_lines;
   logic [1:0] lvl;
   logic [1:0] fall;

   assign raw_lines[WIRE_A] = line_a;
   assign raw_lines[WIRE_B] = line_b;

   altrx_sync #(
      .STAGES    (SYNC_STAGES),
      .WIDTH     (2),
      .RESET_VAL ('1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines),
      .level (lvl),
      .fall  (fall)
   );

   // ---------------- sequencer
   rx_state_e state_q, state_d;
   logic      in_recv;
   logic      tmr_expire;
   logic      tmr_clear;

   assign in_recv = (state_q == RX_RECV);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RX_IDLE_HI: if (lvl[WIRE_A])  state_d = RX_WAIT_LO;
         RX_WAIT_LO: if (!lvl[WIRE_A]) state_d = RX_WAIT_HI;
         RX_WAIT_HI: if (lvl[WIRE_A])  state_d = RX_RECV;
         RX_RECV:    if (tmr_expire)   state_d = RX_IDLE_HI;
         default:                      state_d = RX_IDLE_HI;
      endcase
   end

   // ---------------- bit capture
   logic [IDX_W-1:0]  bit_idx;
   logic              strobe_a;
   logic              take;
   logic              bit_val;
   logic              word_done;
   logic [DATA_W-1:0] word_value;

   // Data is the synchronized level of the other wire in the strobe cycle.
   assign take      = in_recv && (strobe_a ? fall[WIRE_A] : fall[WIRE_B]);
   assign bit_val   = strobe_a ? lvl[WIRE_B] : lvl[WIRE_A];
   assign tmr_clear = take && (bit_idx == CLR_IDX);

   altrx_assemble #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (!in_recv),
      .take       (take),
      .bit_val    (bit_val),
      .bit_idx    (bit_idx),
      .strobe_a   (strobe_a),
      .word_done  (word_done),
      .word_value (word_value)
   );

   // ---------------- inactivity timer
   altrx_timer #(
      .LIMIT (TIMEOUT_CYCLES)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_recv),
      .clear  (tmr_clear),
      .expire (tmr_expire)
   );

   // ---------------- outputs and byte counter
   logic [DATA_W-1:0]  data_q;
   logic               valid_q;
   logic               done_q;
   logic [COUNT_W-1:0] total_q;
   logic [COUNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE_HI;
         data_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         total_q <= '0;
         count_q <= '0;
      end else begin
         state_q <= state_d;
         valid_q <= word_done;
         done_q  <= tmr_expire;
         if (word_done) data_q <= word_value;
         if (tmr_expire) begin
            // A byte finishing in the expiry cycle still counts.
            total_q <= count_q + COUNT_W'(word_done);
            count_q <= '0;
         end else if (word_done) begin
            count_q <= count_q + 1'b1;
         end else if (!in_recv) begin
            count_q <= '0;
         end
      end
   end

   assign byte_data   = data_q;
   assign byte_valid  = valid_q;
   assign frame_done  = done_q;
   assign frame_count = total_q;

endmodule

// File: rtl/altrx_rx_chk.sv
// Temporal checks on the receiver, attached by bind.
module altrx_rx_chk
   import altrx_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      byte_valid,
   input logic      frame_done,
   input logic      tmr_expire,
   input rx_state_e state_q
);

   AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);                                   // R5

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);                                   // R7

   AST_EXPIRE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire |=> frame_done);                                    // R6

   AST_EXPIRE_ONLY_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire |-> state_q == RX_RECV);                            // R7

   AST_DONE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> state_q == RX_IDLE_HI);                         // R11

   AST_BYTE_FROM_RECV: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(state_q) == RX_RECV);                     // R1

endmodule

bind altrx_rx altrx_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_valid (byte_valid),
   .frame_done (frame_done),
   .tmr_expire (tmr_expire),
   .state_q    (state_q)
);

// File: tb/sim_altrx_rx.sv
`timescale 1ns/1ps
module sim_altrx_rx;

   localparam int LIMIT = 200;
   localparam int STG   = 2;
   localparam int LAT   = STG + 1;
   localparam int CW    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_a = 1'b1;
   logic       line_b = 1'b1;
   logic [7:0] byte_data;
   logic       byte_valid;
   logic       frame_done;
   logic [CW-1:0] frame_count;

   altrx_rx #(
      .DATA_W (8), .SYNC_STAGES (STG), .TIMEOUT_CYCLES (LIMIT),
      .CLEAR_BIT (4), .COUNT_W (CW)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .line_a (line_a), .line_b (line_b),
      .byte_data (byte_data), .byte_valid (byte_valid),
      .frame_done (frame_done), .frame_count (frame_count)
   );

   always #2 clk = ~clk;   // 250 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    checks = 0;
   int    fails  = 0;
   bit    finished = 1'b0;
   string tag = "R7";

   logic [7:0] exp_b [0:1023];
   int         exp_c [0:1023];
   int         wr = 0;
   int         rd = 0;
   bit         armed = 1'b0;
   int         exp_done = 0;
   int         frame_bytes = 0;
   logic [7:0] cur = 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Output monitor, sampling away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rd < wr && cyc == exp_c[rd]) begin
            // R2 R3 R4 R5: byte content and delivery cycle
            chk(byte_valid && byte_data == exp_b[rd], "R2 R3 R4 R5 byte",
                {byte_valid, byte_data}, {1'b1, exp_b[rd]});
            rd++;
         end else if (byte_valid) begin
            chk(1'b0, "R5 R11 unexpected byte_valid", byte_data, 0);
         end
         if (armed && cyc == exp_done) begin
            chk(frame_done, {tag, " R6 frame_done timing"}, frame_done, 1);
            chk(frame_count == frame_bytes[CW-1:0], {tag, " R7 frame_count"},
                frame_count, frame_bytes[CW-1:0]);
            armed = 1'b0;
         end else if (frame_done) begin
            chk(1'b0, {tag, " R6 R10 unexpected frame_done"}, 1, 0);
         end
      end
   end

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic wait_frame_end();
      while (armed) @(negedge clk);
      waitn(2);
   endtask

   // R1: wire A high, low, high arms the receiver and starts the timer.
   task automatic arm(input int h);
      while (armed) @(negedge clk);
      waitn(4);
      line_a = 1'b1; line_b = 1'b1;
      waitn(h + 4);
      line_a = 1'b0;
      waitn(h + 4);
      line_a = 1'b1;
      armed = 1'b1;
      exp_done = cyc + LAT + LIMIT;
      frame_bytes = 0;
      waitn(h + 4);
   endtask

   // One bit: odd positions strobed by A with data on B, even the reverse.
   task automatic send_bit(input int idx, input bit v, input int h, input int at);
      bit sa;
      bit active;
      sa = ((7 - idx) % 2) == 0;
      if (sa) line_b = v; else line_a = v;
      if (at > 0) wait_until(at); else waitn(h);
      if (sa) line_a = 1'b0; else line_b = 1'b0;
      active = armed && (cyc + LAT <= exp_done);
      if (active) begin
         cur[idx] = v;
         if (idx == 4) exp_done = cyc + LAT + LIMIT;
         if (idx == 0) begin
            exp_b[wr] = cur;
            exp_c[wr] = cyc + LAT;
            wr++;
            frame_bytes++;
         end
      end
      waitn(h);
      if (sa) line_b = 1'b1; else line_a = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] b, input int h);
      for (int i = 7; i >= 0; i--) send_bit(i, b[i], h, 0);
   endtask

   int unsigned seed_init;

   initial begin
      seed_init = $urandom(32'h5EED_A17E);
      waitn(4);
      // R12: reset state
      chk(byte_valid == 1'b0, "R12 byte_valid", byte_valid, 0);
      chk(frame_done == 1'b0, "R12 frame_done", frame_done, 0);
      chk(byte_data == 8'h00, "R12 byte_data", byte_data, 0);
      chk(frame_count == '0, "R12 frame_count", frame_count, 0);
      rst_n = 1'b1;
      waitn(3);

      // R1: wire B noise while not armed must not yield bytes
      tag = "R1";
      for (int i = 0; i < 6; i++) begin line_b = ~line_b; waitn(3); end
      arm(2);
      send_byte(8'hA5, 1);
      send_byte(8'h3C, 3);
      wait_frame_end();

      // R7: frame with no bytes still ends, count zero
      tag = "R7";
      arm(1);
      wait_frame_end();

      // R8: three stray bits discarded
      tag = "R8";
      arm(2);
      send_byte(8'h12, 2);
      for (int i = 7; i >= 5; i--) send_bit(i, 1'b1, 2, 0);
      wait_frame_end();
      tag = "R8";
      arm(1);
      send_byte(8'h81, 1);
      wait_frame_end();

      // R6: partial byte through bit 4 restarts the timer, still discarded
      tag = "R6";
      arm(2);
      send_byte(8'hFF, 2);
      for (int i = 7; i >= 3; i--) send_bit(i, 1'b0, 2, 0);
      wait_frame_end();

      // R9: byte completes in the expiry cycle
      tag = "R9";
      arm(1);
      send_byte(8'h5A, 2);
      for (int i = 7; i >= 1; i--) send_bit(i, (8'hC3 >> i) & 1, 1, 0);
      send_bit(0, 1'b1, 1, exp_done - LAT);
      wait_frame_end();

      // R11: same, one cycle too late; byte dropped and edge ignored
      tag = "R11";
      arm(1);
      send_byte(8'h69, 2);
      for (int i = 7; i >= 1; i--) send_bit(i, (8'hE7 >> i) & 1, 1, 0);
      send_bit(0, 1'b0, 1, exp_done - LAT + 1);
      wait_frame_end();

      // R10: timer restart in the expiry cycle wins
      tag = "R10";
      arm(2);
      for (int i = 7; i >= 5; i--) send_bit(i, (8'hB4 >> i) & 1, 2, 0);
      send_bit(4, 1'b1, 1, exp_done - LAT);
      for (int i = 3; i >= 0; i--) send_bit(i, (8'hB4 >> i) & 1, 2, 0);
      wait_frame_end();

      // Random frames (R2 R3 R4 R5 R7)
      for (int f = 0; f < 30; f++) begin
         int nb;
         int h;
         tag = "R5";
         nb = $urandom_range(4, 1);
         h  = $urandom_range(4, 1);
         arm(h);
         for (int k = 0; k < nb; k++) begin
            send_byte(8'($urandom_range(255)), $urandom_range(4, 1));
            waitn($urandom_range(20, 0));
         end
         wait_frame_end();
      end

      waitn(10);
      chk(rd == wr, "R5 all bytes delivered", rd, wr);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule